// File: doc/BRIEF.md
# Bidirectional Reset Source Detector

This block sits on the processor side of a shared, active-low reset line that any device on the board may pull down. When a reset begins, whether a local fault requests it or another device pulls the line low, the block pulls the line down itself for a fixed number of E-clock periods. It then lets go, waits a short settle window and looks at the line again. If the line has already come back high, nothing else was holding it, so the reset started inside the processor. The alternate vector, which keeps stored state, then applies. If the line is still low, some other device is holding it. The reset counts as external, and the block waits for the line to rise before it finishes and selects the normal vector.

All timing counts E-clock enable pulses, not system clocks, so the windows follow the processor bus rate. The sensed pin passes through a synchronizer before any decision uses it. A falling edge seen on the line while the block is idle also starts a sequence. A sequence runs to completion without interruption: any request that arrives while it runs is dropped, not queued.

Top module: `rst_src_detect`

## Requirements
- R1: Out of reset, `pin_pull_dn`, `done` and `src_internal` are all 0.
- R2: When `int_req` is 1 in an idle cycle, `pin_pull_dn` becomes 1 in the next cycle.
- R3: `pin_pull_dn` stays 1 for exactly DRIVE_TICKS (default 4) `eclk_en` pulses, whatever the spacing of those pulses. It drops in the cycle after the last of them.
- R4: After release, the synchronized pin level is sampled on the SETTLE_TICKS-th (default 2) `eclk_en` pulse. If the sampled level is high, `src_internal` becomes 1 and `done` is 1 in the next cycle.
- R5: If the sampled level is low, the reset counts as external. `src_internal` becomes 0, and `done` rises three clock edges after the pin goes high, because of the two synchronizer stages plus the decision register.
- R6: `done` is a single-cycle pulse and never coincides with `pin_pull_dn`. `src_internal` changes only in a cycle where `done` is 1, and holds its value until the next `done`.
- R7: When the pin falls while the block is idle, a sequence starts. `pin_pull_dn` becomes 1 after the third rising clock edge that follows the fall.
- R8: Neither `int_req` nor pin edges that occur during a sequence are kept. After `done`, the block stays idle until a new request arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| eclk_en | input | 1 | E-clock enable; one pulse per bus period |
| int_req | input | 1 | Internal reset request (watchdog, clock fault) |
| pin_in | input | 1 | Sensed level of the shared reset line (asynchronous) |
| pin_pull_dn | output | 1 | 1 enables the pull-down on the reset line |
| done | output | 1 | One-cycle strobe at the end of a sequence |
| src_internal | output | 1 | 1 = internal source (alternate vector), 0 = external (normal vector) |

## Verification
The bench generates `eclk_en` on a divider it controls. It counts the pulses it observes while the pull-down is active, then counts pulses again after release. It releases its own external hold exactly one pulse before the sample, or exactly on the sample pulse, which places the two sides of the decision one E-clock apart. Each latency check counts falling clock edges from the moment the stimulus changes. `pin_pull_dn` is expected on the first falling edge after an `int_req` cycle and on the fourth after a pin fall. `done` is expected on the falling edge right after the sample in the internal case, and on the fourth falling edge after the line is released in the external case. Every output is sampled half a period after the rising edge, so each of these counts maps to a fixed number of registers.

// File: rtl/rsd_pkg.sv
package rsd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_DRIVE  = 3'd1,
        ST_SETTLE = 3'd2,
        ST_WAIT   = 3'd3,
        ST_DONE   = 3'd4
    } rsd_state_e;

    // Conditioned view of the shared reset line
    typedef struct packed {
        logic level;   // synchronized pin level
        logic fall;    // one-cycle high-to-low indication
    } rsd_pin_t;

    // Control from the sequencer to the E-clock counter
    typedef struct packed {
        logic run;     // count enable pulses in this state
        logic settle;  // 1 = settle window, 0 = drive window
    } rsd_cnt_ctl_t;

    function automatic int unsigned rsd_cnt_width(input int unsigned a,
                                                  input int unsigned b);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m < 2) ? 1 : $clog2(m);
    endfunction

endpackage

// File: rtl/rsd_pin_sense.sv
module rsd_pin_sense #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pin_in,
    output rsd_pkg::rsd_pin_t pin
);
    logic [SYNC_STAGES-1:0] chain_q;
    logic                   prev_q;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '1;
                else     chain_q <= pin_in;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '1;
                else     chain_q <= {chain_q[SYNC_STAGES-2:0], pin_in};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b1;
        else     prev_q <= chain_q[SYNC_STAGES-1];
    end

    always_comb begin
        pin.level = chain_q[SYNC_STAGES-1];
        pin.fall  = prev_q & ~chain_q[SYNC_STAGES-1];
    end
endmodule

// File: rtl/rsd_tick_cnt.sv
module rsd_tick_cnt #(
    parameter int unsigned DRIVE_TICKS  = 4,
    parameter int unsigned SETTLE_TICKS = 2,
    parameter int unsigned CNT_W        = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  eclk_en,
    input  rsd_pkg::rsd_cnt_ctl_t ctl,
    output logic                  last
);
    localparam logic [CNT_W-1:0] DRIVE_END  = CNT_W'(DRIVE_TICKS - 1);
    localparam logic [CNT_W-1:0] SETTLE_END = CNT_W'(SETTLE_TICKS - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] end_val;
    logic             tick;

    always_comb begin
        end_val = ctl.settle ? SETTLE_END : DRIVE_END;
        tick    = ctl.run & eclk_en;
        last    = tick & (cnt_q == end_val);
    end

    always_ff @(posedge clk) begin
        if (rst || !ctl.run) cnt_q <= '0;
        else if (last)       cnt_q <= '0;
        else if (tick)       cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/rsd_fsm.sv
module rsd_fsm (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  int_req,
    input  rsd_pkg::rsd_pin_t     pin,
    input  logic                  last,
    output rsd_pkg::rsd_cnt_ctl_t ctl,
    output logic                  pull_dn,
    output logic                  done,
    output logic                  src_internal
);
    import rsd_pkg::*;

    rsd_state_e state_q, state_d;
    logic       src_q, src_d;

    always_comb begin
        state_d = state_q;
        src_d   = src_q;
        unique case (state_q)
            ST_IDLE: begin
                if (int_req || pin.fall) state_d = ST_DRIVE;
            end
            ST_DRIVE: begin
                if (last) state_d = ST_SETTLE;
            end
            ST_SETTLE: begin
                if (last) begin
                    if (pin.level) begin
                        state_d = ST_DONE;
                        src_d   = 1'b1;
                    end else begin
                        state_d = ST_WAIT;
                    end
                end
            end
            ST_WAIT: begin
                if (pin.level) begin
                    state_d = ST_DONE;
                    src_d   = 1'b0;
                end
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            src_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            src_q   <= src_d;
        end
    end

    always_comb begin
        ctl.run      = (state_q == ST_DRIVE) || (state_q == ST_SETTLE);
        ctl.settle   = (state_q == ST_SETTLE);
        pull_dn      = (state_q == ST_DRIVE);
        done         = (state_q == ST_DONE);
        src_internal = src_q;
    end
endmodule

// File: rtl/rst_src_detect.sv
module rst_src_detect #(
    parameter int unsigned DRIVE_TICKS  = 4,
    parameter int unsigned SETTLE_TICKS = 2,
    parameter int unsigned SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic eclk_en,
    input  logic int_req,
    input  logic pin_in,
    output logic pin_pull_dn,
    output logic done,
    output logic src_internal
);
    localparam int unsigned CNT_W = rsd_pkg::rsd_cnt_width(DRIVE_TICKS, SETTLE_TICKS);

    rsd_pkg::rsd_pin_t     pin;
    rsd_pkg::rsd_cnt_ctl_t ctl;
    logic                  last;

    rsd_pin_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
        .clk    (clk),
        .rst    (rst),
        .pin_in (pin_in),
        .pin    (pin)
    );

    rsd_tick_cnt #(
        .DRIVE_TICKS  (DRIVE_TICKS),
        .SETTLE_TICKS (SETTLE_TICKS),
        .CNT_W        (CNT_W)
    ) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .eclk_en (eclk_en),
        .ctl     (ctl),
        .last    (last)
    );

    rsd_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .int_req      (int_req),
        .pin          (pin),
        .last         (last),
        .ctl          (ctl),
        .pull_dn      (pin_pull_dn),
        .done         (done),
        .src_internal (src_internal)
    );
endmodule

// File: rtl/rsd_checker.sv
module rsd_checker #(
    parameter int unsigned DRIVE_TICKS = 4
) (
    input logic clk,
    input logic rst,
    input logic eclk_en,
    input logic pin_pull_dn,
    input logic done,
    input logic src_internal
);
    int unsigned drive_seen_q;

    always_ff @(posedge clk) begin
        if (rst || !pin_pull_dn)          drive_seen_q <= 0;
        else if (eclk_en)                 drive_seen_q <= drive_seen_q + 1;
    end

    AST_DRIVE_LEN: assert property (@(posedge clk) disable iff (rst)
        $fell(pin_pull_dn) |-> (drive_seen_q == DRIVE_TICKS)); // R3
    AST_DRIVE_BOUND: assert property (@(posedge clk) disable iff (rst)
        pin_pull_dn |-> (drive_seen_q < DRIVE_TICKS)); // R3
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R6
    AST_DONE_NOT_DRIVING: assert property (@(posedge clk) disable iff (rst)
        done |-> !pin_pull_dn); // R6
    AST_SRC_HOLD: assert property (@(posedge clk) disable iff (rst)
        (src_internal != $past(src_internal)) |-> done); // R6
    AST_DONE_AFTER_RELEASE: assert property (@(posedge clk) disable iff (rst)
        $fell(pin_pull_dn) |-> !done); // R4
endmodule

bind rst_src_detect rsd_checker #(.DRIVE_TICKS(DRIVE_TICKS)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .eclk_en      (eclk_en),
    .pin_pull_dn  (pin_pull_dn),
    .done         (done),
    .src_internal (src_internal)
);

// File: tb/rst_src_detect_tb.sv
module rst_src_detect_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic eclk_en = 1'b0;
    logic int_req = 1'b0;
    logic ext_low = 1'b0;
    logic pin_in;
    logic pin_pull_dn, done, src_internal;

    int checks = 0;
    int fails  = 0;
    int eclk_div = 4;
    bit finished = 1'b0;

    always #2 clk = ~clk; // 250 MHz

    assign pin_in = ~(pin_pull_dn | ext_low);

    rst_src_detect u_dut (
        .clk          (clk),
        .rst          (rst),
        .eclk_en      (eclk_en),
        .int_req      (int_req),
        .pin_in       (pin_in),
        .pin_pull_dn  (pin_pull_dn),
        .done         (done),
        .src_internal (src_internal)
    );

    // E-clock enable generator, changes 1 ns after the rising edge
    initial begin
        int div_cnt;
        div_cnt = 0;
        forever begin
            @(posedge clk);
            #1;
            div_cnt = (div_cnt + 1 >= eclk_div) ? 0 : div_cnt + 1;
            eclk_en = (div_cnt == 0);
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Count eclk pulses while the pull-down is on; returns at first negedge with it off
    task automatic count_drive(output int pulses);
        pulses = 0;
        while (pin_pull_dn) begin
            if (eclk_en) pulses++;
            @(negedge clk);
        end
    endtask

    // Count negedges until done is seen
    task automatic wait_done(output int cyc);
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!done && cyc < 500);
    endtask

    // Internal request; hold the line externally until `rel` settle pulses have passed
    // (rel < 0: no external hold at all)
    task automatic seq_int(input string tag, input int rel, input bit exp_int);
        int pulses, seen, cyc;
        @(posedge clk); #1;
        int_req = 1'b1;
        ext_low = (rel >= 0);
        @(posedge clk); #1;
        int_req = 1'b0;
        @(negedge clk);
        check(pin_pull_dn == 1'b1, {tag, " R2 pull-down after request"}, pin_pull_dn, 1);
        count_drive(pulses);
        check(pulses == 4, {tag, " R3 drive pulses"}, pulses, 4);
        if (rel == 0) begin
            ext_low = 1'b0;
        end else if (rel > 0) begin
            seen = 0;
            forever begin
                if (eclk_en) seen++;
                if (seen == rel) break;
                @(negedge clk);
            end
            @(posedge clk); #1;
            ext_low = 1'b0;
        end
        wait_done(cyc);
        check(done == 1'b1, {tag, " R4/R5 done seen"}, done, 1);
        check(src_internal == exp_int, {tag, " R4/R5 source flag"}, src_internal, exp_int);
        if (!exp_int)
            check(cyc == 4, {tag, " R5 done latency after line rise"}, cyc, 4);
        @(negedge clk);
        check(done == 1'b0, {tag, " R6 done single cycle"}, done, 0);
        check(src_internal == exp_int, {tag, " R6 source held"}, src_internal, exp_int);
    endtask

    initial begin
        int cyc, pulses, seen;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check(pin_pull_dn == 1'b0, "R1 reset pull-down", pin_pull_dn, 0);
        check(done == 1'b0, "R1 reset done", done, 0);
        check(src_internal == 1'b0, "R1 reset source", src_internal, 0);
        repeat (5) @(negedge clk);

        // Internal, no other driver
        seq_int("int_free", -1, 1'b1);
        // Held externally, released at once after drive: internal
        seq_int("int_rel0", 0, 1'b1);
        // Released one pulse before sampling: still internal (boundary)
        seq_int("int_rel1", 1, 1'b1);
        // Released on the sample pulse: external (boundary)
        seq_int("ext_rel2", 2, 1'b0);
        // Held long: external
        seq_int("ext_rel5", 5, 1'b0);

        // R3 with slower E-clock
        eclk_div = 7;
        repeat (10) @(negedge clk);
        seq_int("slow_eclk", -1, 1'b1);
        eclk_div = 4;
        repeat (10) @(negedge clk);

        // R7: external fall while idle starts a sequence
        @(posedge clk); #1;
        ext_low = 1'b1;
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!pin_pull_dn && cyc < 50);
        check(cyc == 4, "R7 pull-down latency after pin fall", cyc, 4);
        count_drive(pulses);
        check(pulses == 4, "R7 R3 drive pulses on external start", pulses, 4);
        seen = 0;
        forever begin
            if (eclk_en) seen++;
            if (seen == 6) break;
            @(negedge clk);
        end
        @(posedge clk); #1;
        ext_low = 1'b0;
        wait_done(cyc);
        check(src_internal == 1'b0, "R7 R5 external source", src_internal, 0);
        check(cyc == 4, "R7 R5 done latency", cyc, 4);
        repeat (5) @(negedge clk);

        // R8: requests and pin edges during a sequence are dropped
        @(posedge clk); #1;
        int_req = 1'b1;
        @(posedge clk); #1;
        int_req = 1'b0;
        repeat (3) @(posedge clk);
        #1 int_req = 1'b1; ext_low = 1'b1;
        @(posedge clk); #1;
        int_req = 1'b0; ext_low = 1'b0;
        wait_done(cyc);
        check(src_internal == 1'b1, "R8 source of first sequence", src_internal, 1);
        seen = 0;
        repeat (40) begin
            @(negedge clk);
            if (pin_pull_dn || done) seen++;
        end
        check(seen == 0, "R8 no sequence after done", seen, 0);
        check(src_internal == 1'b1, "R8 R6 source held while idle", src_internal, 1);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule